// File: doc/BRIEF.md
# NAND Cache-Program Sequencer

This block sits on the host side of a NAND flash command/address/data bus and programs a series of pages using cache programming. Each page request arrives on a valid/ready front end with a row address, a start column, a byte count, a last-page flag and a two-plane flag. The page data follows on a separate byte stream. The block emits one bus cycle per clock and marks it with a write strobe or a read strobe. A write cycle carries a command, an address byte or a data byte. A read cycle samples a status byte.

Intermediate pages are closed with the cache confirm code. The data register of the die is then free while the previous page is still being written. The last page is closed with the final confirm code. After every confirm the block polls status until the relevant ready bit is set. It uses the cached-fail bit to report the page before the current one, and the plain fail bit to report the final page. Any byte of the data stream can carry a column jump, which the block turns into a random-data-input command with new column cycles. When several dies share the bus, the status command selects one die with the page's row address.

Top module: `nps_cache_prog`

## Requirements
- R1: After reset `req_ready` is 1, no bus strobe is active and `res_valid` is 0.
- R2: A page is emitted as command 80h, then COL_CYC column bytes (low byte first), then ROW_CYC row bytes (low byte first), then `req_len` data write cycles carrying the stream bytes in order, then the confirm command. Command cycles set `bus_cle`, address cycles set `bus_ale`, data cycles set neither, and all three set `bus_we`.
- R3: The confirm code is 11h when the two-plane flag is set, otherwise 10h when the last flag is set, otherwise 15h.
- R4: A stream byte presented with `dat_jump`=1 is preceded on the bus by command 85h and COL_CYC bytes of `dat_col` (low first). The byte itself follows and counts toward `req_len` once.
- R5: Each status poll is command 78h followed by ROW_CYC row bytes of the current page and one read cycle (`bus_re`) when DIES>1, or command 70h and one read cycle when DIES=1. The poll repeats until the wanted ready bit is 1.
- R6: The wanted bit is status bit 6 (ready for new commands) after 11h and 15h, and status bit 5 (array ready) after 10h.
- R7: After a 15h poll finishes, an outstanding earlier cached page is reported with `res_fail` equal to status bit 1. The current page then becomes outstanding. The first page of a series reports nothing at this point.
- R8: After a 10h poll finishes, an outstanding page is reported with status bit 1, and the last page is reported in the next cycle with status bit 0. With nothing outstanding, only the last page is reported, with bit 0.
- R9: A page closed with 11h reports no result of its own. Its group is reported under the row of the page that closes the group.
- R10: When `cfg_poll_max` reads pass without the wanted bit, a single result with `res_tmo`=1 and the current row is reported. Any outstanding page is discarded and the block returns to idle.
- R11: `req_ready` is 1 only in idle and drops after a request is accepted. `dat_ready` is 1 only in a cycle that writes a data byte.
- R12: A page with `req_len`=0 goes straight from the last address byte to the confirm command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_poll_max | input | CNT_W | Status reads allowed before a timeout |
| req_valid | input | 1 | Page request valid |
| req_ready | output | 1 | Page request accepted when valid |
| req_row | input | 8*ROW_CYC | Page row address |
| req_col | input | 8*COL_CYC | Start column |
| req_len | input | LEN_W | Data bytes in the page |
| req_last | input | 1 | Page ends the cached series |
| req_plane | input | 1 | Page is a non-final plane of a two-plane group |
| dat_valid | input | 1 | Stream byte valid |
| dat_ready | output | 1 | Stream byte written this cycle |
| dat_byte | input | 8 | Stream byte |
| dat_jump | input | 1 | Move the column before this byte |
| dat_col | input | 8*COL_CYC | New column for a jump |
| bus_cle | output | 1 | Cycle is a command |
| bus_ale | output | 1 | Cycle is an address byte |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_dq_o | output | 8 | Byte driven on write cycles |
| bus_dq_i | input | 8 | Status byte sampled on read cycles |
| res_valid | output | 1 | Page result valid |
| res_row | output | 8*ROW_CYC | Row of the reported page |
| res_fail | output | 1 | Program failure |
| res_tmo | output | 1 | Status poll timed out |

## Verification
The bench attributes each fail bit to the right page: the cached-fail bit goes to the previous page and the plain fail bit to the final page. A design that swaps the two bits, or drops the second result after a final page, gives rows or fail values that the scoreboard does not expect. After a final confirm the bench returns status bytes with the ready-for-commands bit set but the array-ready bit clear, so a design that stops on the wrong bit leaves a status read unissued. The bench also covers these cases, which catch jump commands in the wrong place, stale confirm codes and leftover outstanding-page state:
- a column jump on the first data byte and one in mid-page;
- a zero-length page;
- a two-plane group;
- a timeout with a page outstanding, followed by a clean final page.

// File: rtl/nps_pkg.sv
package nps_pkg;
    localparam logic [7:0] OP_OPEN      = 8'h80;
    localparam logic [7:0] OP_JUMP      = 8'h85;
    localparam logic [7:0] OP_CACHE     = 8'h15;
    localparam logic [7:0] OP_FINAL     = 8'h10;
    localparam logic [7:0] OP_PLANE     = 8'h11;
    localparam logic [7:0] OP_STAT_ALL  = 8'h70;
    localparam logic [7:0] OP_STAT_ONE  = 8'h78;

    localparam int SB_FAIL  = 0;
    localparam int SB_FAILC = 1;
    localparam int SB_ARDY  = 5;
    localparam int SB_RDY   = 6;

    typedef struct packed {
        logic       cle;
        logic       ale;
        logic       we;
        logic       re;
        logic [7:0] dq;
    } nbus_t;

    typedef enum logic [2:0] {
        S_IDLE, S_OPEN, S_ADDR, S_DATA, S_JADDR, S_CONF, S_POLL, S_TAIL
    } seq_st_e;

    typedef enum logic [1:0] {
        P_IDLE, P_CMD, P_ADDR, P_READ
    } poll_st_e;
endpackage

// File: rtl/nps_addr_gen.sv
module nps_addr_gen #(
    parameter int COL_CYC = 2,
    parameter int ROW_CYC = 3,
    parameter int IW      = 3
) (
    input  logic [IW-1:0]          idx,
    input  logic [8*COL_CYC-1:0]   col,
    input  logic [8*ROW_CYC-1:0]   row,
    output logic [7:0]             byte_o
);
    localparam int NCYC = COL_CYC + ROW_CYC;

    logic [8*NCYC-1:0] flat;
    assign flat = {row, col};

    always_comb begin
        byte_o = '0;
        for (int i = 0; i < NCYC; i++) begin
            if (idx == IW'(i)) byte_o = flat[i*8 +: 8];
        end
    end
endmodule

// File: rtl/nps_poll.sv
module nps_poll
    import nps_pkg::*;
#(
    parameter int DIES    = 1,
    parameter int ROW_CYC = 3,
    parameter int CNT_W   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  want_ardy,
    input  logic [8*ROW_CYC-1:0]  row,
    input  logic [CNT_W-1:0]      limit,
    input  logic [7:0]            din,
    output nbus_t                 bus_o,
    output logic                  done,
    output logic                  tmo,
    output logic                  st_fail,
    output logic                  st_failc
);
    localparam int AI_W = (ROW_CYC > 1) ? $clog2(ROW_CYC) : 1;

    typedef struct packed {
        poll_st_e        st;
        logic [AI_W-1:0] ai;
        logic [CNT_W-1:0] cnt;
        logic            want_a;
    } poll_t;

    poll_t q, d;
    logic [7:0] stat_op;
    logic       with_addr;
    logic [7:0] row_byte;
    logic       hit;
    logic       spent;

    generate
        if (DIES > 1) begin : g_one_die
            assign stat_op   = OP_STAT_ONE;
            assign with_addr = 1'b1;
        end else begin : g_all_dies
            assign stat_op   = OP_STAT_ALL;
            assign with_addr = 1'b0;
        end
    endgenerate

    always_comb begin
        row_byte = '0;
        for (int i = 0; i < ROW_CYC; i++) begin
            if (q.ai == AI_W'(i)) row_byte = row[i*8 +: 8];
        end
    end

    assign hit      = q.want_a ? din[SB_ARDY] : din[SB_RDY];
    assign spent    = ({1'b0, q.cnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, limit};
    assign st_fail  = din[SB_FAIL];
    assign st_failc = din[SB_FAILC];

    always_comb begin
        d     = q;
        bus_o = '0;
        done  = 1'b0;
        tmo   = 1'b0;
        case (q.st)
            P_IDLE: begin
                if (start) begin
                    d.st     = P_CMD;
                    d.cnt    = '0;
                    d.want_a = want_ardy;
                end
            end
            P_CMD: begin
                bus_o.cle = 1'b1;
                bus_o.we  = 1'b1;
                bus_o.dq  = stat_op;
                d.ai      = '0;
                d.st      = with_addr ? P_ADDR : P_READ;
            end
            P_ADDR: begin
                bus_o.ale = 1'b1;
                bus_o.we  = 1'b1;
                bus_o.dq  = row_byte;
                if (q.ai == AI_W'(ROW_CYC - 1)) d.st = P_READ;
                else                            d.ai = q.ai + 1'b1;
            end
            P_READ: begin
                bus_o.re = 1'b1;
                if (hit) begin
                    done = 1'b1;
                    d.st = P_IDLE;
                end else if (spent) begin
                    done = 1'b1;
                    tmo  = 1'b1;
                    d.st = P_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                    d.st  = P_CMD;
                end
            end
            default: d.st = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/nps_cache_prog.sv
module nps_cache_prog
    import nps_pkg::*;
#(
    parameter int COL_CYC = 2,
    parameter int ROW_CYC = 3,
    parameter int LEN_W   = 12,
    parameter int CNT_W   = 16,
    parameter int DIES    = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNT_W-1:0]      cfg_poll_max,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [8*ROW_CYC-1:0]  req_row,
    input  logic [8*COL_CYC-1:0]  req_col,
    input  logic [LEN_W-1:0]      req_len,
    input  logic                  req_last,
    input  logic                  req_plane,
    input  logic                  dat_valid,
    output logic                  dat_ready,
    input  logic [7:0]            dat_byte,
    input  logic                  dat_jump,
    input  logic [8*COL_CYC-1:0]  dat_col,
    output logic                  bus_cle,
    output logic                  bus_ale,
    output logic                  bus_we,
    output logic                  bus_re,
    output logic [7:0]            bus_dq_o,
    input  logic [7:0]            bus_dq_i,
    output logic                  res_valid,
    output logic [8*ROW_CYC-1:0]  res_row,
    output logic                  res_fail,
    output logic                  res_tmo
);
    localparam int COL_W = 8 * COL_CYC;
    localparam int ROW_W = 8 * ROW_CYC;
    localparam int NADR  = COL_CYC + ROW_CYC;
    localparam int AI_W  = $clog2(NADR + 1);

    typedef struct packed {
        seq_st_e          st;
        logic [AI_W-1:0]  ai;
        logic [LEN_W-1:0] cnt;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] jcol;
        logic [LEN_W-1:0] len;
        logic             last;
        logic             plane;
        logic             jdone;
        logic             pend_v;
        logic [ROW_W-1:0] pend_row;
        logic             hold_fail;
        logic             res_v;
        logic [ROW_W-1:0] res_row;
        logic             res_fail;
        logic             res_tmo;
    } seq_t;

    seq_t  q, d;
    nbus_t own_bus, poll_bus, out_bus;
    logic [7:0] adr_byte;
    logic       poll_start, poll_done, poll_tmo, st_fail, st_failc;

    nps_addr_gen #(.COL_CYC(COL_CYC), .ROW_CYC(ROW_CYC), .IW(AI_W)) u_adr (
        .idx    (q.ai),
        .col    ((q.st == S_JADDR) ? q.jcol : q.col),
        .row    (q.row),
        .byte_o (adr_byte)
    );

    nps_poll #(.DIES(DIES), .ROW_CYC(ROW_CYC), .CNT_W(CNT_W)) u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (poll_start),
        .want_ardy (q.last & ~q.plane),
        .row       (q.row),
        .limit     (cfg_poll_max),
        .din       (bus_dq_i),
        .bus_o     (poll_bus),
        .done      (poll_done),
        .tmo       (poll_tmo),
        .st_fail   (st_fail),
        .st_failc  (st_failc)
    );

    always_comb begin
        d          = q;
        d.res_v    = 1'b0;
        d.res_tmo  = 1'b0;
        own_bus    = '0;
        req_ready  = 1'b0;
        dat_ready  = 1'b0;
        poll_start = 1'b0;
        case (q.st)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    d.row   = req_row;
                    d.col   = req_col;
                    d.len   = req_len;
                    d.last  = req_last;
                    d.plane = req_plane;
                    d.st    = S_OPEN;
                end
            end
            S_OPEN: begin
                own_bus.cle = 1'b1;
                own_bus.we  = 1'b1;
                own_bus.dq  = OP_OPEN;
                d.ai    = '0;
                d.cnt   = '0;
                d.jdone = 1'b0;
                d.st    = S_ADDR;
            end
            S_ADDR: begin
                own_bus.ale = 1'b1;
                own_bus.we  = 1'b1;
                own_bus.dq  = adr_byte;
                if (q.ai == AI_W'(NADR - 1))
                    d.st = (q.len == '0) ? S_CONF : S_DATA;
                else
                    d.ai = q.ai + 1'b1;
            end
            S_DATA: begin
                if (dat_valid) begin
                    if (dat_jump && !q.jdone) begin
                        own_bus.cle = 1'b1;
                        own_bus.we  = 1'b1;
                        own_bus.dq  = OP_JUMP;
                        d.jcol = dat_col;
                        d.ai   = '0;
                        d.st   = S_JADDR;
                    end else begin
                        own_bus.we = 1'b1;
                        own_bus.dq = dat_byte;
                        dat_ready  = 1'b1;
                        d.jdone    = 1'b0;
                        d.cnt      = q.cnt + 1'b1;
                        if (q.cnt == q.len - 1'b1) d.st = S_CONF;
                    end
                end
            end
            S_JADDR: begin
                own_bus.ale = 1'b1;
                own_bus.we  = 1'b1;
                own_bus.dq  = adr_byte;
                if (q.ai == AI_W'(COL_CYC - 1)) begin
                    d.jdone = 1'b1;
                    d.st    = S_DATA;
                end else begin
                    d.ai = q.ai + 1'b1;
                end
            end
            S_CONF: begin
                own_bus.cle = 1'b1;
                own_bus.we  = 1'b1;
                own_bus.dq  = q.plane ? OP_PLANE : (q.last ? OP_FINAL : OP_CACHE);
                poll_start  = 1'b1;
                d.st        = S_POLL;
            end
            S_POLL: begin
                if (poll_done) begin
                    d.st = S_IDLE;
                    if (poll_tmo) begin
                        d.res_v    = 1'b1;
                        d.res_row  = q.row;
                        d.res_fail = 1'b0;
                        d.res_tmo  = 1'b1;
                        d.pend_v   = 1'b0;
                    end else if (q.plane) begin
                        d.st = S_IDLE;
                    end else if (q.last) begin
                        d.pend_v = 1'b0;
                        if (q.pend_v) begin
                            d.res_v     = 1'b1;
                            d.res_row   = q.pend_row;
                            d.res_fail  = st_failc;
                            d.hold_fail = st_fail;
                            d.st        = S_TAIL;
                        end else begin
                            d.res_v    = 1'b1;
                            d.res_row  = q.row;
                            d.res_fail = st_fail;
                        end
                    end else begin
                        if (q.pend_v) begin
                            d.res_v    = 1'b1;
                            d.res_row  = q.pend_row;
                            d.res_fail = st_failc;
                        end
                        d.pend_v   = 1'b1;
                        d.pend_row = q.row;
                    end
                end
            end
            S_TAIL: begin
                d.res_v    = 1'b1;
                d.res_row  = q.row;
                d.res_fail = q.hold_fail;
                d.st       = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_bus   = (q.st == S_POLL) ? poll_bus : own_bus;
    assign bus_cle   = out_bus.cle;
    assign bus_ale   = out_bus.ale;
    assign bus_we    = out_bus.we;
    assign bus_re    = out_bus.re;
    assign bus_dq_o  = out_bus.dq;
    assign res_valid = q.res_v;
    assign res_row   = q.res_row;
    assign res_fail  = q.res_fail;
    assign res_tmo   = q.res_tmo;
endmodule

// File: rtl/nps_cache_prog_chk.sv
module nps_cache_prog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       dat_ready,
    input logic       bus_cle,
    input logic       bus_ale,
    input logic       bus_we,
    input logic       bus_re,
    input logic [7:0] bus_dq_o,
    input logic       res_valid,
    input logic       res_fail,
    input logic       res_tmo
);
    // R11
    data_take_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_ready |-> (bus_we && !bus_cle && !bus_ale && !bus_re));

    // R2
    single_cycle_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_cle, bus_ale, bus_re}) && !(bus_we && bus_re));

    // R2
    open_then_address_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_cle && bus_dq_o == 8'h80) |=> (bus_we && bus_ale));

    // R5
    confirm_then_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_cle && (bus_dq_o == 8'h10 || bus_dq_o == 8'h11 || bus_dq_o == 8'h15))
        |=> (bus_we && bus_cle && (bus_dq_o == 8'h70 || bus_dq_o == 8'h78)));

    // R11
    accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    timeout_is_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_tmo |-> (res_valid && !res_fail));
endmodule

bind nps_cache_prog nps_cache_prog_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .dat_ready (dat_ready),
    .bus_cle   (bus_cle),
    .bus_ale   (bus_ale),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_dq_o  (bus_dq_o),
    .res_valid (res_valid),
    .res_fail  (res_fail),
    .res_tmo   (res_tmo)
);

// File: tb/nps_cache_prog_tb.sv
`timescale 1ns/1ps
module nps_cache_prog_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_poll_max = 8'd8;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_row = '0;
    logic [15:0] req_col = '0;
    logic [7:0]  req_len = '0;
    logic        req_last = 1'b0;
    logic        req_plane = 1'b0;
    logic        dat_valid = 1'b0;
    logic        dat_ready;
    logic [7:0]  dat_byte = '0;
    logic        dat_jump = 1'b0;
    logic [15:0] dat_col = '0;
    logic        bus_cle, bus_ale, bus_we, bus_re;
    logic [7:0]  bus_dq_o;
    logic [7:0]  bus_dq_i = '0;
    logic        res_valid;
    logic [23:0] res_row;
    logic        res_fail, res_tmo;

    always #2.5 clk = ~clk;

    nps_cache_prog #(.COL_CYC(2), .ROW_CYC(3), .LEN_W(8), .CNT_W(8), .DIES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_poll_max(cfg_poll_max),
        .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row),
        .req_col(req_col), .req_len(req_len), .req_last(req_last), .req_plane(req_plane),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
        .dat_jump(dat_jump), .dat_col(dat_col),
        .bus_cle(bus_cle), .bus_ale(bus_ale), .bus_we(bus_we), .bus_re(bus_re),
        .bus_dq_o(bus_dq_o), .bus_dq_i(bus_dq_i),
        .res_valid(res_valid), .res_row(res_row), .res_fail(res_fail), .res_tmo(res_tmo)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [9:0]  exp_bus[$];
    string       bus_tag[$];
    logic [24:0] dat_q[$];
    logic [25:0] exp_res[$];
    string       res_tag[$];
    bit          pend_v = 0;
    logic [23:0] pend_row = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // kinds: 0 command, 1 address, 2 data, 3 status read (byte = value returned)
    task automatic pb(input logic [1:0] k, input logic [7:0] b, input string tag);
        exp_bus.push_back({k, b});
        bus_tag.push_back(tag);
    endtask

    task automatic pr(input bit tmo, input bit fl, input logic [23:0] row, input string tag);
        exp_res.push_back({tmo, fl, row});
        res_tag.push_back(tag);
    endtask

    task automatic page(input logic [23:0] row, input logic [15:0] col, input int len,
                        input bit last, input bit plane, input int jpos, input logic [15:0] jcol,
                        input int nbusy, input logic [7:0] bval, input bit tmo,
                        input logic [7:0] fstat);
        pb(0, 8'h80, "R2 open");
        pb(1, col[7:0], "R2 col0");
        pb(1, col[15:8], "R2 col1");
        for (int i = 0; i < 3; i++) pb(1, row[i*8 +: 8], "R2 row");
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'(row[7:0] + 8'(i * 7) + 8'd3);
            if (i == jpos) begin
                pb(0, 8'h85, "R4 jump cmd");
                pb(1, jcol[7:0], "R4 jump col0");
                pb(1, jcol[15:8], "R4 jump col1");
                dat_q.push_back({1'b1, jcol, b});
            end else begin
                dat_q.push_back({1'b0, 16'h0, b});
            end
            pb(2, b, "R2 data");
        end
        pb(0, plane ? 8'h11 : (last ? 8'h10 : 8'h15), "R3 confirm");
        for (int k = 0; k < nbusy + (tmo ? 0 : 1); k++) begin
            pb(0, 8'h78, "R5 status cmd");
            for (int i = 0; i < 3; i++) pb(1, row[i*8 +: 8], "R5 die row");
            pb(3, (k < nbusy) ? bval : fstat, "R6 status read");
        end
        if (tmo) begin
            pr(1, 0, row, "R10 timeout");
            pend_v = 0;
        end else if (plane) begin
        end else if (last) begin
            if (pend_v) pr(0, fstat[1], pend_row, "R8 prior page");
            pr(0, fstat[0], row, "R8 last page");
            pend_v = 0;
        end else begin
            if (pend_v) pr(0, fstat[1], pend_row, "R7 prior page");
            pend_v = 1;
            pend_row = row;
        end
        @(negedge clk);
        req_row = row; req_col = col; req_len = 8'(len);
        req_last = last; req_plane = plane; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11 busy after accept", {31'b0, req_ready}, 32'h0);
    endtask

    task automatic drain;
        while (exp_bus.size() != 0 || exp_res.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // bus and result monitor
    initial begin
        forever begin
            @(negedge clk);
            if (dat_q.size() != 0) begin
                {dat_jump, dat_col, dat_byte} = dat_q[0];
                dat_valid = 1'b1;
            end else begin
                dat_valid = 1'b0;
                dat_jump  = 1'b0;
            end
            #1;
            if (rst_n && (bus_we || bus_re)) begin
                logic [1:0] k;
                k = bus_cle ? 2'd0 : bus_ale ? 2'd1 : bus_re ? 2'd3 : 2'd2;
                if (exp_bus.size() == 0) begin
                    chk(0, "R2 unexpected bus cycle", {22'b0, k, bus_dq_o}, 32'h0);
                end else begin
                    logic [9:0] e;
                    string t;
                    e = exp_bus.pop_front();
                    t = bus_tag.pop_front();
                    chk(k == e[9:8], t, {30'b0, k}, {30'b0, e[9:8]});
                    if (k == 2'd3) bus_dq_i = e[7:0];
                    else chk(bus_dq_o == e[7:0], t, {24'b0, bus_dq_o}, {24'b0, e[7:0]});
                end
                if (k == 2'd2) begin
                    chk(dat_ready == 1'b1, "R11 data taken", {31'b0, dat_ready}, 32'h1);
                    if (dat_q.size() != 0) void'(dat_q.pop_front());
                end else begin
                    chk(dat_ready == 1'b0, "R11 no take", {31'b0, dat_ready}, 32'h0);
                end
            end
            if (rst_n && res_valid) begin
                if (exp_res.size() == 0) begin
                    chk(0, "R7 unexpected result", {6'b0, res_tmo, res_fail, res_row}, 32'h0);
                end else begin
                    logic [25:0] e;
                    string t;
                    e = exp_res.pop_front();
                    t = res_tag.pop_front();
                    chk({res_tmo, res_fail, res_row} == e, t,
                        {6'b0, res_tmo, res_fail, res_row}, {6'b0, e});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired pending=%0d expected=0", exp_bus.size());
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_we == 1'b0 && bus_re == 1'b0, "R1 no strobe in reset", {30'b0, bus_we, bus_re}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", {31'b0, req_ready}, 32'h1);
        chk(res_valid == 1'b0, "R1 no result after reset", {31'b0, res_valid}, 32'h0);
        chk(bus_we == 1'b0 && bus_re == 1'b0, "R1 bus quiet", {30'b0, bus_we, bus_re}, 32'h0);

        // R8 R6: single final page; RDY-only bytes must not end the poll
        page(24'h01_0203, 16'h0010, 4, 1, 0, -1, 16'h0, 2, 8'h40, 0, 8'h60);
        drain();
        // R7 cached series, R4 mid-page jump, R8 two results
        page(24'h00_1100, 16'h0000, 3, 0, 0, -1, 16'h0, 1, 8'h00, 0, 8'h40);
        page(24'h00_1101, 16'h0004, 5, 0, 0, 2, 16'h0123, 0, 8'h00, 0, 8'h42);
        page(24'h00_1102, 16'h0008, 2, 1, 0, -1, 16'h0, 1, 8'h40, 0, 8'h61);
        drain();
        // R9 two-plane group, R4 jump on first byte
        page(24'h02_0040, 16'h0000, 3, 0, 1, 0, 16'h0777, 1, 8'h00, 0, 8'h40);
        page(24'h02_0041, 16'h0000, 2, 1, 0, -1, 16'h0, 0, 8'h00, 0, 8'h60);
        drain();
        // R12 zero-length final page
        page(24'h03_0005, 16'h0020, 0, 1, 0, -1, 16'h0, 0, 8'h00, 0, 8'h61);
        drain();
        // R10 timeout with a page outstanding
        page(24'h04_0001, 16'h0000, 2, 0, 0, -1, 16'h0, 0, 8'h00, 0, 8'h40);
        drain();
        cfg_poll_max = 8'd3;
        page(24'h04_0002, 16'h0000, 2, 0, 0, -1, 16'h0, 3, 8'h00, 1, 8'h00);
        drain();
        cfg_poll_max = 8'd8;
        page(24'h04_0003, 16'h0000, 1, 1, 0, -1, 16'h0, 0, 8'h00, 0, 8'h62);
        drain();
        chk(req_ready == 1'b1, "R11 idle at end", {31'b0, req_ready}, 32'h1);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule